// File: doc/BRIEF.md
# Single-Cycle Nine-Instruction Processor Core

This block is a 32-bit processor that fetches, decodes and completes one instruction on every clock edge. It understands three register-to-register arithmetic and logic forms plus set-on-less-than, word load and word store with a base register and a signed 16-bit offset, branch-if-equal, and an absolute jump within the current 256 MB region. Program and data live in two small word arrays inside the block. Both arrays are written from dedicated preload ports, which are meant for use while the core is held in reset. Reads from both arrays are combinational.

The core exposes its program counter and a registered store-event port. Every executed store shows its byte address and data one edge after it runs. Software-visible results can therefore be seen without reaching into the core: a later store instruction writes out the value of any register.

Instruction fields sit at fixed positions: opcode [31:26], first source [25:21], second source or load target [20:16], destination [15:11], shift amount [10:6] (ignored) and function code [5:0]. For immediate forms, [15:0] holds the offset.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, `pc_o` is 0 after each clock edge and `st_valid_o` is 0; reset is synchronous and active high.
- R2: For any instruction other than a taken branch or a jump, `pc_o` advances by 4 on each edge.
- R3: Opcode 0x00 with function 0x20 (add) or 0x22 (subtract) writes rs+rt or rs-rt into register rd.
- R4: Opcode 0x00 with function 0x24 (and) or 0x25 (or) writes the bitwise result of rs and rt into rd.
- R5: Opcode 0x00 with function 0x2A writes 1 into rd when rs is less than rt as signed 32-bit numbers, and writes 0 otherwise.
- R6: Opcode 0x23 loads the data word at byte address rs + sign-extended [15:0] into register rt.
- R7: Opcode 0x2B stores rt at byte address rs + sign-extended [15:0]. On the next edge, `st_valid_o` is 1 and `st_addr_o`/`st_data_o` carry that address and data.
- R8: Opcode 0x04 compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by 2; otherwise it is PC+4.
- R9: Opcode 0x02 sets the next PC to {PC+4 [31:28], instr[25:0], 2'b00}.
- R10: Register 0 reads as zero, and a write to it is discarded.
- R11: Any other opcode, and any opcode-0x00 function code outside the five above, writes no register and no memory; it only advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_load_we | input | 1 | Program array write strobe |
| imem_load_addr | input | $clog2(IMEM_WORDS) | Program array word index |
| imem_load_data | input | 32 | Program word to write |
| dmem_load_we | input | 1 | Data array preload strobe (takes precedence over stores) |
| dmem_load_addr | input | $clog2(DMEM_WORDS) | Data array word index |
| dmem_load_data | input | 32 | Data word to write |
| pc_o | output | 32 | Current program counter |
| st_valid_o | output | 1 | A store ran on the previous edge |
| st_addr_o | output | 32 | Byte address of that store |
| st_data_o | output | 32 | Data of that store |

## Verification
The bench builds the core with a 64-word program array and a 32-word data array. With these sizes the 33-instruction test program fits, and every store address up to byte 96 lands inside data memory without wrapping. Under these sizes a store followed by a load from the same word, and a negative offset from a loaded base register, both resolve to real words. The bench can therefore check that store data round-trips through memory and back through the register file. The program ends in a backward branch to itself, so the jump target region and the self-loop are both reached well inside the run.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam int XLEN = 32;
  localparam int NREGS = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BREQ  = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    use_imm;
    logic    mem_rd;
    logic    mem_wr;
    logic    wb_mem;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_ram.sv
module sc_ram #(
  parameter int WORDS = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

  // R3: a permitted write is visible in the array after the edge
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> regs[$past(wa)] == $past(wd));

  // R10: register 0 keeps its cleared value even when targeted
  assert_r0_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '0) |=> regs[0] == '0);
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_decode.sv
module sc_decode
  import sc_core_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '0;
    ctl.alu_op = ALU_AND;
    case (op)
      OP_RTYPE: begin
        ctl.dst_rd = 1'b1;
        ctl.reg_we = 1'b1;
        case (funct)
          FN_ADD:  ctl.alu_op = ALU_ADD;
          FN_SUB:  ctl.alu_op = ALU_SUB;
          FN_AND:  ctl.alu_op = ALU_AND;
          FN_OR:   ctl.alu_op = ALU_OR;
          FN_SLT:  ctl.alu_op = ALU_SLT;
          default: ctl.reg_we = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctl.reg_we  = 1'b1;
        ctl.use_imm = 1'b1;
        ctl.mem_rd  = 1'b1;
        ctl.wb_mem  = 1'b1;
        ctl.alu_op  = ALU_ADD;
      end
      OP_STORE: begin
        ctl.use_imm = 1'b1;
        ctl.mem_wr  = 1'b1;
        ctl.alu_op  = ALU_ADD;
      end
      OP_BREQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      OP_JUMP: ctl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          imem_load_we,
  input  logic [$clog2(IMEM_WORDS)-1:0] imem_load_addr,
  input  logic [31:0]                   imem_load_data,
  input  logic                          dmem_load_we,
  input  logic [$clog2(DMEM_WORDS)-1:0] dmem_load_addr,
  input  logic [31:0]                   dmem_load_data,
  output logic [31:0]                   pc_o,
  output logic                          st_valid_o,
  output logic [31:0]                   st_addr_o,
  output logic [31:0]                   st_data_o
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);
  localparam int RAW = $clog2(NREGS);

  logic [XLEN-1:0] pc_q, pc_plus4, br_tgt, jmp_tgt, pc_next;
  logic [XLEN-1:0] instr, imm_sx, rs_val, rt_val, alu_b, alu_y;
  logic [XLEN-1:0] ram_q, ld_data, wb_data;
  logic            alu_zero, take_br;
  logic [RAW-1:0]  wa;
  ctrl_t           ctl;

  logic            dm_we;
  logic [DAW-1:0]  dm_waddr;
  logic [XLEN-1:0] dm_wdata;

  // program array
  sc_ram #(.WORDS(IMEM_WORDS), .W(XLEN)) u_imem (
    .clk(clk), .we(imem_load_we), .waddr(imem_load_addr), .wdata(imem_load_data),
    .raddr(pc_q[IAW+1:2]), .rdata(instr)
  );

  sc_decode u_dec (.op(instr[31:26]), .funct(instr[5:0]), .ctl(ctl));

  assign wa = ctl.dst_rd ? instr[15:11] : instr[20:16];

  sc_regfile #(.NREG(NREGS), .W(XLEN)) u_rf (
    .clk(clk), .rst(rst), .we(ctl.reg_we & ~rst), .wa(wa), .wd(wb_data),
    .ra_a(instr[25:21]), .ra_b(instr[20:16]), .rd_a(rs_val), .rd_b(rt_val)
  );

  assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign alu_b  = ctl.use_imm ? imm_sx : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a(rs_val), .b(alu_b), .op(ctl.alu_op), .y(alu_y), .zero(alu_zero)
  );

  // data array: preload port wins over a store in the same cycle
  always_comb begin
    if (dmem_load_we) begin
      dm_we    = 1'b1;
      dm_waddr = dmem_load_addr;
      dm_wdata = dmem_load_data;
    end else begin
      dm_we    = ctl.mem_wr & ~rst;
      dm_waddr = alu_y[DAW+1:2];
      dm_wdata = rt_val;
    end
  end

  sc_ram #(.WORDS(DMEM_WORDS), .W(XLEN)) u_dmem (
    .clk(clk), .we(dm_we), .waddr(dm_waddr), .wdata(dm_wdata),
    .raddr(alu_y[DAW+1:2]), .rdata(ram_q)
  );

  assign ld_data = ctl.mem_rd ? ram_q : '0;
  assign wb_data = ctl.wb_mem ? ld_data : alu_y;

  // next-PC selection
  assign pc_plus4 = pc_q + 32'd4;
  assign br_tgt   = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
  assign jmp_tgt  = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign take_br  = ctl.branch & alu_zero;

  always_comb begin
    if (ctl.jump)     pc_next = jmp_tgt;
    else if (take_br) pc_next = br_tgt;
    else              pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= '0;
      st_valid_o <= 1'b0;
      st_addr_o  <= '0;
      st_data_o  <= '0;
    end else begin
      pc_q       <= pc_next;
      st_valid_o <= ctl.mem_wr;
      st_addr_o  <= alu_y;
      st_data_o  <= rt_val;
    end
  end

  assign pc_o = pc_q;

  logic unused_bits;
  assign unused_bits = ^{instr[10:6], pc_q[1:0], pc_q[XLEN-1:IAW+2],
                         alu_y[1:0], alu_y[XLEN-1:DAW+2], imm_sx[XLEN-1:XLEN-2]};

  // R2: sequential flow advances by one word
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!ctl.jump && !take_br) |=> pc_q == $past(pc_q) + 32'd4);

  // R8: taken compare-equal branch lands at the word offset
  assert_branch_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl.branch && alu_zero && !ctl.jump) |=>
      pc_q == $past(pc_q) + 32'd4 + {$past(imm_sx[XLEN-3:0]), 2'b00});

  // R9: jump keeps region bits and takes the 26-bit word target
  assert_jump_R9: assert property (@(posedge clk) disable iff (rst)
    ctl.jump |=> pc_q[27:0] == {$past(instr[25:0]), 2'b00});

  // R7: every executed store appears on the store port one edge later
  assert_store_port_R7: assert property (@(posedge clk) disable iff (rst)
    ctl.mem_wr |=> (st_valid_o && st_addr_o == $past(alu_y) && st_data_o == $past(rt_val)));

  // R11: at most one of load, store, branch, jump per instruction
  assert_one_kind_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.mem_rd, ctl.mem_wr, ctl.branch, ctl.jump}));
endmodule

// File: tb/test_sc_core.sv
module test_sc_core;
  localparam int IW = 64;
  localparam int DW = 32;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  imem_load_we = 1'b0;
  logic [$clog2(IW)-1:0] imem_load_addr = '0;
  logic [31:0]           imem_load_data = '0;
  logic                  dmem_load_we = 1'b0;
  logic [$clog2(DW)-1:0] dmem_load_addr = '0;
  logic [31:0]           dmem_load_data = '0;
  logic [31:0]           pc_o, st_addr_o, st_data_o;
  logic                  st_valid_o;

  sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) i_sc_core (
    .clk(clk), .rst(rst),
    .imem_load_we(imem_load_we), .imem_load_addr(imem_load_addr), .imem_load_data(imem_load_data),
    .dmem_load_we(dmem_load_we), .dmem_load_addr(dmem_load_addr), .dmem_load_data(dmem_load_data),
    .pc_o(pc_o), .st_valid_o(st_valid_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
  );

  always #10 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  bit run = 1'b0;

  logic [31:0] exp_pc[$];
  string       pc_tag[$];
  logic [31:0] exp_sa[$];
  logic [31:0] exp_sd[$];
  string       st_tag[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] rty(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] ity(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic put_i(input int idx, input logic [31:0] w);
    @(negedge clk);
    imem_load_we = 1'b1; imem_load_addr = 6'(idx); imem_load_data = w;
    @(negedge clk);
    imem_load_we = 1'b0;
  endtask

  task automatic put_d(input int idx, input logic [31:0] w);
    @(negedge clk);
    dmem_load_we = 1'b1; dmem_load_addr = 5'(idx); dmem_load_data = w;
    @(negedge clk);
    dmem_load_we = 1'b0;
  endtask

  task automatic want_st(input logic [31:0] a, input logic [31:0] d, input string tag);
    exp_sa.push_back(a); exp_sd.push_back(d); st_tag.push_back(tag);
  endtask

  // monitor: compare PC trace and store events against the scoreboard
  always @(negedge clk) begin
    if (run) begin
      if (exp_pc.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_pc.pop_front();
        t = pc_tag.pop_front();
        chk(pc_o == e, t, pc_o, e);
      end
      if (st_valid_o) begin
        if (exp_sa.size() == 0) begin
          chk(1'b0, "R11 unexpected store", st_addr_o, 32'hFFFF_FFFF);
        end else begin
          logic [31:0] ea, ed;
          string t;
          ea = exp_sa.pop_front(); ed = exp_sd.pop_front(); t = st_tag.pop_front();
          chk(st_addr_o == ea, {t, " R7 addr"}, st_addr_o, ea);
          chk(st_data_o == ed, {t, " data"}, st_data_o, ed);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R2 watchdog: got %0d pending expected 0", exp_pc.size());
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    // data preload
    put_d(0, 32'h0000_0007);
    put_d(1, 32'hFFFF_FFF0);
    put_d(2, 32'h1234_5678);
    put_d(3, 32'h0000_0050);
    // program
    put_i(0,  ity(6'h23, 0, 1, 0));           // r1 = 7
    put_i(1,  ity(6'h23, 0, 2, 4));           // r2 = -16
    put_i(2,  rty(1, 2, 3, 6'h20));           // r3 = -9
    put_i(3,  ity(6'h2B, 0, 3, 64));
    put_i(4,  rty(1, 2, 4, 6'h22));           // r4 = 23
    put_i(5,  ity(6'h2B, 0, 4, 68));
    put_i(6,  ity(6'h23, 0, 6, 8));           // r6 = 0x12345678
    put_i(7,  rty(6, 2, 5, 6'h24));           // r5 = and
    put_i(8,  rty(6, 1, 7, 6'h25));           // r7 = or
    put_i(9,  ity(6'h2B, 0, 5, 72));
    put_i(10, ity(6'h2B, 0, 7, 76));
    put_i(11, rty(2, 1, 8, 6'h2A));           // -16 < 7
    put_i(12, rty(1, 2, 9, 6'h2A));           // 7 < -16
    put_i(13, ity(6'h2B, 0, 8, 80));
    put_i(14, ity(6'h2B, 0, 9, 84));
    put_i(15, rty(1, 1, 0, 6'h20));           // write to r0
    put_i(16, ity(6'h2B, 0, 0, 88));
    put_i(17, ity(6'h23, 0, 12, 12));         // r12 = 80
    put_i(18, ity(6'h23, 12, 10, -8));        // r10 = mem[72]
    put_i(19, ity(6'h2B, 12, 10, -4));        // store to 76
    put_i(20, {6'h3F, 5'd0, 5'd1, 16'h0005}); // unknown opcode
    put_i(21, rty(6, 6, 1, 6'h27));           // unknown function
    put_i(22, ity(6'h2B, 0, 1, 92));
    put_i(23, ity(6'h04, 1, 2, 5));           // not taken
    put_i(24, ity(6'h04, 1, 1, 2));           // taken to 108
    put_i(25, ity(6'h2B, 0, 1, 96));
    put_i(26, ity(6'h2B, 0, 1, 96));
    put_i(27, ity(6'h2B, 0, 2, 96));
    put_i(28, {6'h02, 26'd32});               // jump to 128
    put_i(29, ity(6'h2B, 0, 1, 100));
    put_i(30, ity(6'h2B, 0, 1, 100));
    put_i(31, ity(6'h2B, 0, 1, 100));
    put_i(32, ity(6'h04, 0, 0, -1));          // self loop

    // scoreboard: PC trace
    for (int a = 4; a <= 96; a += 4) begin
      exp_pc.push_back(32'(a));
      pc_tag.push_back((a == 96) ? "R8 not-taken pc" : (a == 84 || a == 88) ? "R11 pc" : "R2 pc");
    end
    exp_pc.push_back(32'd108); pc_tag.push_back("R8 taken pc");
    exp_pc.push_back(32'd112); pc_tag.push_back("R2 pc");
    exp_pc.push_back(32'd128); pc_tag.push_back("R9 jump pc");
    exp_pc.push_back(32'd128); pc_tag.push_back("R8 backward pc");
    exp_pc.push_back(32'd128); pc_tag.push_back("R8 backward pc");

    // scoreboard: store events
    want_st(32'd64, 32'hFFFF_FFF7, "R3 add");
    want_st(32'd68, 32'h0000_0017, "R3 sub");
    want_st(32'd72, 32'h1234_5670, "R4 and");
    want_st(32'd76, 32'h1234_567F, "R4 or");
    want_st(32'd80, 32'h0000_0001, "R5 slt true");
    want_st(32'd84, 32'h0000_0000, "R5 slt false");
    want_st(32'd88, 32'h0000_0000, "R10 r0");
    want_st(32'd76, 32'h1234_5670, "R6 load neg offset");
    want_st(32'd92, 32'h0000_0007, "R11 r1 kept");
    want_st(32'd96, 32'hFFFF_FFF0, "R8 skipped stores");

    // reset state (R1)
    @(negedge clk);
    chk(pc_o == 32'd0, "R1 pc in reset", pc_o, 32'd0);
    chk(st_valid_o == 1'b0, "R1 store idle in reset", 32'(st_valid_o), 32'd0);

    rst = 1'b0;
    @(posedge clk);
    run = 1'b1;

    while (exp_pc.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_sa.size() == 0, "R7 all stores seen", 32'(exp_sa.size()), 32'd0);
    chk(pc_o == 32'd128, "R8 loop holds", pc_o, 32'd128);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule